// File: doc/BRIEF.md
# Address-Rebasing Request Bridge for a Reconfigurable Compute Module

This block connects a host-side load/store request port to one reconfigurable compute module. The host sees the module through a window in its physical address space. The window's base and size are held in two configuration registers. An access that lands inside the window is rebased: the window base is subtracted from the host address, and the access is sent to the module as a request carrying a module-private 32-bit virtual address. The module therefore always sees its own address space starting at zero, wherever the host has placed it. An access outside the window never reaches the module. The bridge answers it with an error response.

Both directions use a valid/stop handshake. A request transfers in a cycle where the sender's valid is high and the receiver's stop is low. A presented request holds steady until it transfers. A read that has been handed to the module blocks the host port until the module returns its data word, so at most one read is ever in flight. The module can also issue its own requests toward the host side. That channel and its returning data pass straight through the bridge. The module's interrupt is forwarded after one register stage.

Top module: `xbr_bridge`

## Requirements
- R1: After reset, `cm_vld`, `hst_rsp_vld`, `hst_req_stop` and `irq_out` are 0. The window size register is 0, so every host access is out of window.
- R2: A host request is accepted when `hst_req_vld` is 1 and `hst_req_stop` is 0. If its address A satisfies 0 <= A - base < size, the bridge raises `cm_vld` on the next cycle. On that cycle `cm_addr` equals the low 32 bits of A - base, and `cm_wr` and `cm_wdata` equal the accepted values.
- R3: An accepted host access with A < base or A - base >= size is not forwarded. On the next cycle the bridge drives `hst_rsp_vld` = 1, `hst_rsp_err` = 1 and `hst_rsp_data` = 0. The address base + size - 1 is the last one inside the window.
- R4: While `cm_vld` and `cm_stop` are both 1, the request on `cm_addr`, `cm_wdata` and `cm_wr` stays unchanged on the next cycle, and `hst_req_stop` is 1.
- R5: From the cycle after a read is accepted until the cycle in which `cm_rsp_vld` is sampled, `hst_req_stop` stays 1. No further host request is forwarded during that time.
- R6: When `cm_rsp_vld` is 1 while a read is outstanding, `hst_rsp_vld` is 1 on the next cycle, with `hst_rsp_err` = 0 and `hst_rsp_data` equal to `cm_rsp_data`. A `cm_rsp_vld` with no read outstanding produces no host response.
- R7: An in-window write (`hst_req_wr` = 1) produces no host response.
- R8: In the same cycle, the module request channel (`mrq_vld`, `mrq_wr`, `mrq_addr`, `mrq_data`) appears on `up_vld`, `up_wr`, `up_addr` and `up_data`. `up_stop` appears on `mrq_stop`, and `up_rsp_vld`/`up_rsp_data` appear on `mrq_rsp_vld`/`mrq_rsp_data`.
- R9: `irq_out` equals the value `mod_irq` had one cycle earlier.
- R10: A cycle with `cfg_load` = 1 loads `cfg_base` and `cfg_size`. Requests accepted from the next cycle onward are checked and rebased against the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load window base and size |
| cfg_base | input | PAW | New physical window base |
| cfg_size | input | PAW | New window size in bytes |
| hst_req_vld | input | 1 | Host request valid |
| hst_req_wr | input | 1 | Host request is a write (1) or read (0) |
| hst_req_addr | input | PAW | Host physical address |
| hst_req_wdata | input | DW | Host write data |
| hst_req_stop | output | 1 | Bridge holds off the host |
| hst_rsp_vld | output | 1 | Response to host valid |
| hst_rsp_err | output | 1 | Response is an out-of-window error |
| hst_rsp_data | output | DW | Response read data |
| cm_vld | output | 1 | Request to module valid |
| cm_wr | output | 1 | Request to module is a write |
| cm_addr | output | VAW | Module virtual address |
| cm_wdata | output | DW | Write data to module |
| cm_stop | input | 1 | Module holds off the bridge |
| cm_rsp_vld | input | 1 | Module read data valid |
| cm_rsp_data | input | DW | Module read data |
| mrq_vld | input | 1 | Module-initiated request valid |
| mrq_wr | input | 1 | Module-initiated request is a write |
| mrq_addr | input | VAW | Module-initiated request address |
| mrq_data | input | DW | Module-initiated write data |
| mrq_stop | output | 1 | Host side holds off the module |
| mrq_rsp_vld | output | 1 | Response data to module valid |
| mrq_rsp_data | output | DW | Response data to module |
| up_vld | output | 1 | Module-initiated request toward host valid |
| up_wr | output | 1 | Module-initiated request toward host is a write |
| up_addr | output | VAW | Module-initiated request toward host address |
| up_data | output | DW | Module-initiated write data toward host |
| up_stop | input | 1 | Host side stop for module-initiated requests |
| up_rsp_vld | input | 1 | Host-side response valid |
| up_rsp_data | input | DW | Host-side response data |
| mod_irq | input | 1 | Module interrupt |
| irq_out | output | 1 | Interrupt forwarded to the host side |

## Verification
The bench builds the bridge with a 40-bit physical address, a 32-bit virtual address and 32-bit data. The window is placed above the 4 GiB line, so rebasing has to subtract through the upper address bits, and the low 32 bits of the raw host address differ from the module address. A later reconfiguration moves the window to a small base, which shows that the old range then faults. With these widths the tests reach the exact last-in-window byte, the first byte past the window and the byte just below the base. The tests also hold a request against a stopped module and keep a host request pending across an outstanding read.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  // Kind of response queued toward the host for the next cycle
  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_DATA  = 2'd1,
    RK_FAULT = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/xbr_window.sv
module xbr_window #(
  parameter int PAW = 40,
  parameter int VAW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [PAW-1:0] cfg_base,
  input  logic [PAW-1:0] cfg_size,
  input  logic [PAW-1:0] req_addr,
  output logic           hit,
  output logic [VAW-1:0] vaddr
);
  logic [PAW-1:0] base_q, base_n;
  logic [PAW-1:0] size_q, size_n;
  logic [PAW-1:0] offs;

  always_comb begin
    base_n = base_q;
    size_n = size_q;
    if (cfg_load) begin
      base_n = cfg_base;
      size_n = cfg_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (cfg_load) begin
      base_q <= base_n;
      size_q <= size_n;
    end
  end

  // Unsigned offset: addresses below base wrap to a huge value and miss
  always_comb begin
    offs  = req_addr - base_q;
    hit   = (offs < size_q);
    vaddr = offs[VAW-1:0];
  end
endmodule

// File: rtl/xbr_crq.sv
module xbr_crq
  import xbr_pkg::*;
#(
  parameter int VAW = 32,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  logic           hit,
  input  logic           req_wr,
  input  logic [VAW-1:0] req_vaddr,
  input  logic [DW-1:0]  req_wdata,
  output logic           busy,
  output logic           cm_vld,
  output logic           cm_wr,
  output logic [VAW-1:0] cm_addr,
  output logic [DW-1:0]  cm_wdata,
  input  logic           cm_stop,
  input  logic           cm_rsp_vld,
  input  logic [DW-1:0]  cm_rsp_data,
  output logic           rsp_vld,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_data
);
  logic           vld_q, vld_n;
  logic           wr_q;
  logic [VAW-1:0] addr_q;
  logic [DW-1:0]  wdata_q;
  logic           pend_q, pend_n;
  logic           rvld_q, rerr_q, rerr_n;
  logic [DW-1:0]  rdata_q, rdata_n;
  logic           hold, load_en, rsp_en;
  rsp_kind_e      kind;

  always_comb begin
    hold    = vld_q && cm_stop;
    busy    = hold || pend_q;
    load_en = !hold && acc && hit;
    vld_n   = hold ? 1'b1 : load_en;

    pend_n = pend_q;
    if (cm_rsp_vld) pend_n = 1'b0;
    if (load_en && !req_wr) pend_n = 1'b1;

    if (pend_q && cm_rsp_vld)  kind = RK_DATA;
    else if (acc && !hit)      kind = RK_FAULT;
    else                       kind = RK_NONE;

    rsp_en  = (kind != RK_NONE);
    rerr_n  = (kind == RK_FAULT);
    rdata_n = (kind == RK_DATA) ? cm_rsp_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      rvld_q <= 1'b0;
    end else begin
      vld_q  <= vld_n;
      pend_q <= pend_n;
      rvld_q <= rsp_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      wr_q    <= req_wr;
      addr_q  <= req_vaddr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rerr_q  <= 1'b0;
      rdata_q <= '0;
    end else if (rsp_en) begin
      rerr_q  <= rerr_n;
      rdata_q <= rdata_n;
    end
  end

  assign cm_vld   = vld_q;
  assign cm_wr    = wr_q;
  assign cm_addr  = addr_q;
  assign cm_wdata = wdata_q;
  assign rsp_vld  = rvld_q;
  assign rsp_err  = rerr_q;
  assign rsp_data = rdata_q;
endmodule

// File: rtl/xbr_mrq.sv
module xbr_mrq #(
  parameter int VAW = 32,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mrq_vld,
  input  logic           mrq_wr,
  input  logic [VAW-1:0] mrq_addr,
  input  logic [DW-1:0]  mrq_data,
  output logic           mrq_stop,
  output logic           mrq_rsp_vld,
  output logic [DW-1:0]  mrq_rsp_data,
  output logic           up_vld,
  output logic           up_wr,
  output logic [VAW-1:0] up_addr,
  output logic [DW-1:0]  up_data,
  input  logic           up_stop,
  input  logic           up_rsp_vld,
  input  logic [DW-1:0]  up_rsp_data,
  input  logic           mod_irq,
  output logic           irq_out
);
  logic irq_q, irq_n;

  assign up_vld       = mrq_vld;
  assign up_wr        = mrq_wr;
  assign up_addr      = mrq_addr;
  assign up_data      = mrq_data;
  assign mrq_stop     = up_stop;
  assign mrq_rsp_vld  = up_rsp_vld;
  assign mrq_rsp_data = up_rsp_data;

  always_comb irq_n = mod_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/xbr_bridge.sv
module xbr_bridge #(
  parameter int PAW = 40,
  parameter int VAW = 32,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [PAW-1:0] cfg_base,
  input  logic [PAW-1:0] cfg_size,
  input  logic           hst_req_vld,
  input  logic           hst_req_wr,
  input  logic [PAW-1:0] hst_req_addr,
  input  logic [DW-1:0]  hst_req_wdata,
  output logic           hst_req_stop,
  output logic           hst_rsp_vld,
  output logic           hst_rsp_err,
  output logic [DW-1:0]  hst_rsp_data,
  output logic           cm_vld,
  output logic           cm_wr,
  output logic [VAW-1:0] cm_addr,
  output logic [DW-1:0]  cm_wdata,
  input  logic           cm_stop,
  input  logic           cm_rsp_vld,
  input  logic [DW-1:0]  cm_rsp_data,
  input  logic           mrq_vld,
  input  logic           mrq_wr,
  input  logic [VAW-1:0] mrq_addr,
  input  logic [DW-1:0]  mrq_data,
  output logic           mrq_stop,
  output logic           mrq_rsp_vld,
  output logic [DW-1:0]  mrq_rsp_data,
  output logic           up_vld,
  output logic           up_wr,
  output logic [VAW-1:0] up_addr,
  output logic [DW-1:0]  up_data,
  input  logic           up_stop,
  input  logic           up_rsp_vld,
  input  logic [DW-1:0]  up_rsp_data,
  input  logic           mod_irq,
  output logic           irq_out
);
  logic           win_hit;
  logic [VAW-1:0] win_vaddr;
  logic           busy;
  logic           accept;

  assign hst_req_stop = busy;
  assign accept       = hst_req_vld && !busy;

  xbr_window #(.PAW(PAW), .VAW(VAW)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_base (cfg_base),
    .cfg_size (cfg_size),
    .req_addr (hst_req_addr),
    .hit      (win_hit),
    .vaddr    (win_vaddr)
  );

  xbr_crq #(.VAW(VAW), .DW(DW)) u_crq (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (accept),
    .hit         (win_hit),
    .req_wr      (hst_req_wr),
    .req_vaddr   (win_vaddr),
    .req_wdata   (hst_req_wdata),
    .busy        (busy),
    .cm_vld      (cm_vld),
    .cm_wr       (cm_wr),
    .cm_addr     (cm_addr),
    .cm_wdata    (cm_wdata),
    .cm_stop     (cm_stop),
    .cm_rsp_vld  (cm_rsp_vld),
    .cm_rsp_data (cm_rsp_data),
    .rsp_vld     (hst_rsp_vld),
    .rsp_err     (hst_rsp_err),
    .rsp_data    (hst_rsp_data)
  );

  xbr_mrq #(.VAW(VAW), .DW(DW)) u_mrq (
    .clk          (clk),
    .rst_n        (rst_n),
    .mrq_vld      (mrq_vld),
    .mrq_wr       (mrq_wr),
    .mrq_addr     (mrq_addr),
    .mrq_data     (mrq_data),
    .mrq_stop     (mrq_stop),
    .mrq_rsp_vld  (mrq_rsp_vld),
    .mrq_rsp_data (mrq_rsp_data),
    .up_vld       (up_vld),
    .up_wr        (up_wr),
    .up_addr      (up_addr),
    .up_data      (up_data),
    .up_stop      (up_stop),
    .up_rsp_vld   (up_rsp_vld),
    .up_rsp_data  (up_rsp_data),
    .mod_irq      (mod_irq),
    .irq_out      (irq_out)
  );
endmodule

// File: rtl/xbr_bridge_chk.sv
module xbr_bridge_chk #(
  parameter int VAW = 32,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hst_req_vld,
  input logic           hst_req_stop,
  input logic           hst_rsp_vld,
  input logic           hst_rsp_err,
  input logic [DW-1:0]  hst_rsp_data,
  input logic           cm_vld,
  input logic           cm_wr,
  input logic [VAW-1:0] cm_addr,
  input logic [DW-1:0]  cm_wdata,
  input logic           cm_stop,
  input logic           cm_rsp_vld,
  input logic           mod_irq,
  input logic           irq_out
);
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R2
  fwd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $rose(cm_vld) |-> $past(hst_req_vld && !hst_req_stop));

  // R3
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rsp_vld && hst_rsp_err) |-> (hst_rsp_data == '0));

  // R3
  fault_origin_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (hst_rsp_vld && hst_rsp_err) |-> $past(hst_req_vld && !hst_req_stop));

  // R4
  cm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_vld && cm_stop) |=> (cm_vld && $stable(cm_addr) && $stable(cm_wdata) && $stable(cm_wr)));

  // R5
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_vld && !cm_wr && !cm_stop && !cm_rsp_vld) |=> hst_req_stop);

  // R6
  data_origin_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (hst_rsp_vld && !hst_rsp_err) |-> $past(cm_rsp_vld));

  // R9
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    irq_out == $past(mod_irq));
endmodule

bind xbr_bridge xbr_bridge_chk #(.VAW(VAW), .DW(DW)) u_chk (.*);

// File: tb/xbr_bridge_test.sv
module xbr_bridge_test;
  localparam int CLK_P = 10;
  localparam int PAW = 40;
  localparam int VAW = 32;
  localparam int DW  = 32;
  localparam logic [PAW-1:0] BASE  = 40'h12_3400_0000;
  localparam logic [PAW-1:0] SIZE  = 40'h00_0000_1000;
  localparam logic [PAW-1:0] BASE2 = 40'h00_0000_8000;
  localparam logic [PAW-1:0] SIZE2 = 40'h00_0000_0100;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cfg_load;
  logic [PAW-1:0] cfg_base, cfg_size;
  logic           hst_req_vld, hst_req_wr;
  logic [PAW-1:0] hst_req_addr;
  logic [DW-1:0]  hst_req_wdata;
  logic           hst_req_stop, hst_rsp_vld, hst_rsp_err;
  logic [DW-1:0]  hst_rsp_data;
  logic           cm_vld, cm_wr;
  logic [VAW-1:0] cm_addr;
  logic [DW-1:0]  cm_wdata;
  logic           cm_stop, cm_rsp_vld;
  logic [DW-1:0]  cm_rsp_data;
  logic           mrq_vld, mrq_wr;
  logic [VAW-1:0] mrq_addr;
  logic [DW-1:0]  mrq_data;
  logic           mrq_stop, mrq_rsp_vld;
  logic [DW-1:0]  mrq_rsp_data;
  logic           up_vld, up_wr;
  logic [VAW-1:0] up_addr;
  logic [DW-1:0]  up_data;
  logic           up_stop, up_rsp_vld;
  logic [DW-1:0]  up_rsp_data;
  logic           mod_irq, irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xbr_bridge #(.PAW(PAW), .VAW(VAW), .DW(DW)) uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic host_send(input logic wr, input logic [PAW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    hst_req_vld = 1'b1; hst_req_wr = wr; hst_req_addr = a; hst_req_wdata = d;
    @(posedge clk); #1;
    hst_req_vld = 1'b0;
  endtask

  task automatic load_window(input logic [PAW-1:0] b, input logic [PAW-1:0] s);
    @(negedge clk);
    cfg_load = 1'b1; cfg_base = b; cfg_size = s;
    @(posedge clk); #1;
    cfg_load = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cm_vld", cm_vld, 0);
    chk("R1 hst_rsp_vld", hst_rsp_vld, 0);
    chk("R1 hst_req_stop", hst_req_stop, 0);
    chk("R1 irq_out", irq_out, 0);
    host_send(1'b0, 40'h0, 0);
    chk("R1 empty window err", {hst_rsp_vld, hst_rsp_err}, 2'b11);
    chk("R1 empty window not forwarded", cm_vld, 0);
  endtask

  task automatic t_write();
    load_window(BASE, SIZE);
    host_send(1'b1, BASE + 40'h10, 32'hCAFE_0001);
    chk("R10 R2 cm_vld", cm_vld, 1);
    chk("R2 cm_addr", cm_addr, 32'h10);
    chk("R2 cm_wr", cm_wr, 1);
    chk("R2 cm_wdata", cm_wdata, 32'hCAFE_0001);
    chk("R7 no rsp", hst_rsp_vld, 0);
    @(posedge clk); #1;
    chk("R2 delivered", cm_vld, 0);
    chk("R7 still no rsp", hst_rsp_vld, 0);
  endtask

  task automatic t_bounds();
    host_send(1'b1, BASE + SIZE - 40'h1, 32'h1111_2222);
    chk("R3 last byte forwarded", cm_vld, 1);
    chk("R3 last byte vaddr", cm_addr, 32'hFFF);
    host_send(1'b1, BASE + SIZE, 32'h3);
    chk("R3 past end err", {hst_rsp_vld, hst_rsp_err}, 2'b11);
    chk("R3 past end data", hst_rsp_data, 0);
    chk("R3 past end not forwarded", cm_vld, 0);
    host_send(1'b0, BASE - 40'h1, 0);
    chk("R3 below base err", {hst_rsp_vld, hst_rsp_err}, 2'b11);
    chk("R3 below base not forwarded", cm_vld, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_stall();
    @(negedge clk); cm_stop = 1'b1;
    host_send(1'b1, BASE + 40'h40, 32'hDEAD_BEEF);
    chk("R4 presented", cm_vld, 1);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R4 held vld", cm_vld, 1);
      chk("R4 held addr", cm_addr, 32'h40);
      chk("R4 held data", cm_wdata, 32'hDEAD_BEEF);
      chk("R4 host stopped", hst_req_stop, 1);
    end
    @(negedge clk); cm_stop = 1'b0; #1;
    chk("R4 stop released", hst_req_stop, 0);
    @(posedge clk); #1;
    chk("R4 delivered", cm_vld, 0);
  endtask

  task automatic t_read();
    host_send(1'b0, BASE + 40'h20, 0);
    chk("R2 read vld", cm_vld, 1);
    chk("R2 read wr", cm_wr, 0);
    chk("R2 read addr", cm_addr, 32'h20);
    @(posedge clk); #1;
    chk("R5 read handed", cm_vld, 0);
    chk("R5 stop while pending", hst_req_stop, 1);
    @(negedge clk);
    hst_req_vld = 1'b1; hst_req_wr = 1'b1; hst_req_addr = BASE + 40'h30; hst_req_wdata = 32'h77;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R5 stop held", hst_req_stop, 1);
      chk("R5 nothing forwarded", cm_vld, 0);
      chk("R6 no early rsp", hst_rsp_vld, 0);
    end
    @(negedge clk); cm_rsp_vld = 1'b1; cm_rsp_data = 32'h5A5A_1234;
    @(posedge clk); #1;
    cm_rsp_vld = 1'b0;
    chk("R6 rsp vld", hst_rsp_vld, 1);
    chk("R6 rsp err", hst_rsp_err, 0);
    chk("R6 rsp data", hst_rsp_data, 32'h5A5A_1234);
    chk("R5 stop cleared", hst_req_stop, 0);
    @(posedge clk); #1;
    hst_req_vld = 1'b0;
    chk("R6 rsp one cycle", hst_rsp_vld, 0);
    chk("R5 waiting write now forwarded", cm_vld, 1);
    chk("R5 waiting write addr", cm_addr, 32'h30);
    @(posedge clk); #1;
  endtask

  task automatic t_unsolicited();
    @(negedge clk); cm_rsp_vld = 1'b1; cm_rsp_data = 32'hBAD0_0000;
    @(posedge clk); #1;
    cm_rsp_vld = 1'b0;
    chk("R6 unsolicited ignored", hst_rsp_vld, 0);
    chk("R6 unsolicited no stop", hst_req_stop, 0);
  endtask

  task automatic t_mrq();
    @(negedge clk);
    mrq_vld = 1'b1; mrq_wr = 1'b1; mrq_addr = 32'h0BAD_F00D; mrq_data = 32'h1357_9BDF;
    up_stop = 1'b1; up_rsp_vld = 1'b1; up_rsp_data = 32'h2468_ACE0;
    #1;
    chk("R8 up_vld", up_vld, 1);
    chk("R8 up_wr", up_wr, 1);
    chk("R8 up_addr", up_addr, 32'h0BAD_F00D);
    chk("R8 up_data", up_data, 32'h1357_9BDF);
    chk("R8 mrq_stop", mrq_stop, 1);
    chk("R8 mrq_rsp", {mrq_rsp_vld, mrq_rsp_data}, {1'b1, 32'h2468_ACE0});
    @(negedge clk);
    mrq_vld = 1'b0; up_stop = 1'b0; up_rsp_vld = 1'b0;
    #1;
    chk("R8 idle", {up_vld, mrq_stop, mrq_rsp_vld}, 3'b000);
  endtask

  task automatic t_irq();
    @(negedge clk); mod_irq = 1'b1; #1;
    chk("R9 not yet", irq_out, 0);
    @(posedge clk); #1;
    chk("R9 rise", irq_out, 1);
    @(negedge clk); mod_irq = 1'b0;
    @(posedge clk); #1;
    chk("R9 fall", irq_out, 0);
  endtask

  task automatic t_reconf();
    load_window(BASE2, SIZE2);
    host_send(1'b1, BASE + 40'h10, 32'h5);
    chk("R10 old window faults", {hst_rsp_vld, hst_rsp_err}, 2'b11);
    chk("R10 old window not forwarded", cm_vld, 0);
    host_send(1'b1, BASE2 + 40'hFF, 32'h6);
    chk("R10 new window vld", cm_vld, 1);
    chk("R10 new window vaddr", cm_addr, 32'hFF);
    host_send(1'b0, BASE2 + 40'h100, 0);
    chk("R10 new end faults", {hst_rsp_vld, hst_rsp_err}, 2'b11);
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_base = '0; cfg_size = '0;
    hst_req_vld = 1'b0; hst_req_wr = 1'b0; hst_req_addr = '0; hst_req_wdata = '0;
    cm_stop = 1'b0; cm_rsp_vld = 1'b0; cm_rsp_data = '0;
    mrq_vld = 1'b0; mrq_wr = 1'b0; mrq_addr = '0; mrq_data = '0;
    up_stop = 1'b0; up_rsp_vld = 1'b0; up_rsp_data = '0; mod_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_write();
    t_bounds();
    t_stall();
    t_read();
    t_unsolicited();
    t_mrq();
    t_irq();
    t_reconf();
    finish_run();
  end
endmodule